// File: doc/BRIEF.md
# Translation Lookaside Buffer with Permission Check

This block caches recent virtual-to-physical page translations in a small, fully associative array. It sits between a requester and the memory hierarchy. The requester presents a virtual address, an access type (load or store) and its privilege level. The virtual address is split into a page number (upper bits) and an in-page offset (lower bits). When the page number matches a resident entry, the block does two things in the same cycle, with no memory access: it checks the entry's permissions, and it either delivers the physical address or reports a protection fault. The physical address is the entry's physical page number joined to the unchanged offset.

When no entry matches, the request is stalled and the block asks an external page-table walker for the missing entry. The walker returns the physical page number and the permission bits. The block stores them in a free slot, or in a round-robin victim when no slot is free, and then the stalled request is looked up again. Only one miss can be outstanding at a time. A flush input invalidates the whole array in one cycle.

The request side is valid/ready. The requester raises `req_valid` and holds the address and attributes stable until `req_ready` is high. A request completes in the cycle in which `req_ready` is high, either with `rsp_valid` (a translation) or with `rsp_fault` (a protection fault). The consumer of the response cannot stall it. The walk request is also valid/ready: `walk_valid` and `walk_vpn` are held until `walk_ready`. The refill is a single-cycle `fill_valid` strobe, with no back-pressure.

Top module: `xlat_cache`

## Requirements
- R1: When the request's page number (`req_va[31:12]`) matches a valid entry and the access is permitted, `req_ready` and `rsp_valid` are high in the same cycle. In that cycle `rsp_pa` equals the entry's physical page number followed by `req_va[11:0]`.
- R2: When a lookup finds no matching entry, `req_ready` stays low. From the next cycle, `walk_valid` is high with `walk_vpn` equal to the missed page number, and both hold until `walk_ready` is seen. No other lookup completes while the miss is pending.
- R3: A `fill_valid` strobe is taken only after the walk handshake of a pending miss. It writes a valid entry tagged with the missed page number, and from the next cycle the held request is looked up again. A strobe with no pending miss is ignored.
- R4: A refill goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one (wrapping) only on such a replacement.
- R5: A lookup hit is denied when any of these holds: a user-mode access (`req_user`=1) to an entry whose user bit is 0, a store to an entry whose write bit is 0, or a load from an entry whose read bit is 0. A denied request completes with `rsp_fault`=1 and `rsp_valid`=0. `rsp_valid` and `rsp_fault` are never high together.
- R6: On a completing lookup, `rsp_was_dirty` shows the entry's stored dirty bit. A refill sets this bit from `fill_dirty`. A permitted store sets it; a faulting store leaves it unchanged.
- R7: A `flush` cycle clears every valid bit. During that cycle `req_ready` is low and no miss is raised.
- R8: When a refill is taken in the same cycle as `flush`, the refilled entry stays valid and every other entry is cleared.
- R9: After reset every entry is invalid and `walk_valid`, `rsp_valid` and `rsp_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries this cycle |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request completes this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Translation delivered |
| rsp_fault | output | 1 | Protection fault |
| rsp_pa | output | 32 | Physical address |
| rsp_was_dirty | output | 1 | Stored dirty bit of the matched entry |
| walk_valid | output | 1 | Page-table walk requested |
| walk_ready | input | 1 | Walker accepts request |
| walk_vpn | output | 20 | Page number to walk |
| fill_valid | input | 1 | Refill entry strobe |
| fill_ppn | input | 20 | Refill physical page number |
| fill_read | input | 1 | Refill read permission |
| fill_write | input | 1 | Refill write permission |
| fill_user | input | 1 | Refill user-accessible bit |
| fill_dirty | input | 1 | Refill dirty bit |

## Verification
Flush and refill can fall in the same cycle. The bench provokes this by raising `flush` in the very cycle it strobes the walker's refill. It then judges the outcome at the ports: the refilled page must hit on the next access, and a page that was resident before the flush must miss. A flush in a cycle that carries a valid request is also provoked, and the bench expects `req_ready` low in that cycle, no walk request in the next cycle, and a miss for that page afterwards.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic usr;
    logic dirty;
  } xlat_flags_t;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_ASK  = 2'd1,
    MS_WAIT = 2'd2
  } miss_state_t;

  function automatic logic perm_denied(input xlat_flags_t f,
                                       input logic is_store,
                                       input logic is_user);
    logic deny;
    deny = 1'b0;
    if (is_user && !f.usr) deny = 1'b1;
    if (is_store && !f.wr) deny = 1'b1;
    if (!is_store && !f.rd) deny = 1'b1;
    return deny;
  endfunction

endpackage

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [TAG_W-1:0]   look_tag,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  xlat_flags_t        wr_flags,
  input  logic               dirty_set,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [PPN_W-1:0]   hit_ppn,
  output xlat_flags_t        hit_flags
);

  logic [TAG_W-1:0] tag_q   [ENTRIES];
  logic [PPN_W-1:0] ppn_q   [ENTRIES];
  xlat_flags_t      flags_q [ENTRIES];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[gi] <= 1'b0;
      end else if (sel_w) begin
        valid_vec[gi] <= 1'b1;
      end else if (flush) begin
        valid_vec[gi] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[gi]   <= '0;
        ppn_q[gi]   <= '0;
        flags_q[gi] <= '0;
      end else if (sel_w) begin
        tag_q[gi]   <= wr_tag;
        ppn_q[gi]   <= wr_ppn;
        flags_q[gi] <= wr_flags;
      end else if (dirty_set && hit_vec[gi]) begin
        flags_q[gi].dirty <= 1'b1;
      end
    end

    assign hit_vec[gi] = valid_vec[gi] && (tag_q[gi] == look_tag);
  end

  always_comb begin
    hit_ppn   = '0;
    hit_flags = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn   = hit_ppn   | (ppn_q[i] & {PPN_W{hit_vec[i]}});
      hit_flags = hit_flags | (flags_q[i] & {$bits(xlat_flags_t){hit_vec[i]}});
    end
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign victim_idx = free_found ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance && !free_found) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/xlat_miss_ctl.sv
module xlat_miss_ctl
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             walk_ready,
  input  logic             fill_valid,
  output logic             busy,
  output logic             walk_valid,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             fill_take
);

  miss_state_t      state_q;
  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      vpn_q   <= '0;
    end else begin
      unique case (state_q)
        MS_IDLE: if (miss) begin
          state_q <= MS_ASK;
          vpn_q   <= look_vpn;
        end
        MS_ASK:  if (walk_ready) state_q <= MS_WAIT;
        MS_WAIT: if (fill_valid) state_q <= MS_IDLE;
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != MS_IDLE);
  assign walk_valid = (state_q == MS_ASK);
  assign walk_vpn   = vpn_q;
  assign fill_take  = (state_q == MS_WAIT) && fill_valid;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_was_dirty,
  output logic             walk_valid,
  input  logic             walk_ready,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             fill_valid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_read,
  input  logic             fill_write,
  input  logic             fill_user,
  input  logic             fill_dirty
);

  logic [VPN_W-1:0]   look_vpn;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [PPN_W-1:0]   hit_ppn;
  xlat_flags_t        hit_flags;
  xlat_flags_t        fill_flags;
  logic [IDX_W-1:0]   victim_idx;
  logic               busy;
  logic               fill_take;
  logic               look_ok;
  logic               hit;
  logic               denied;
  logic               miss;
  logic               dirty_set;

  assign look_vpn = req_va[VA_W-1:PAGE_BITS];
  assign look_ok  = req_valid && !busy && !flush;
  assign hit      = |hit_vec;
  assign denied   = perm_denied(hit_flags, req_write, req_user);
  assign miss     = look_ok && !hit;

  assign req_ready     = look_ok && hit;
  assign rsp_valid     = req_ready && !denied;
  assign rsp_fault     = req_ready && denied;
  assign rsp_pa        = {hit_ppn, req_va[PAGE_BITS-1:0]};
  assign rsp_was_dirty = req_ready && hit_flags.dirty;
  assign dirty_set     = rsp_valid && req_write;

  assign fill_flags = '{rd: fill_read, wr: fill_write, usr: fill_user, dirty: fill_dirty};

  xlat_entry_array #(
    .ENTRIES (ENTRIES),
    .TAG_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .look_tag  (look_vpn),
    .wr_en     (fill_take),
    .wr_idx    (victim_idx),
    .wr_tag    (walk_vpn),
    .wr_ppn    (fill_ppn),
    .wr_flags  (fill_flags),
    .dirty_set (dirty_set),
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .hit_ppn   (hit_ppn),
    .hit_flags (hit_flags)
  );

  xlat_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .advance    (fill_take),
    .victim_idx (victim_idx)
  );

  xlat_miss_ctl #(
    .VPN_W (VPN_W)
  ) u_miss (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss       (miss),
    .look_vpn   (look_vpn),
    .walk_ready (walk_ready),
    .fill_valid (fill_valid),
    .busy       (busy),
    .walk_valid (walk_valid),
    .walk_vpn   (walk_vpn),
    .fill_take  (fill_take)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic               walk_valid,
  input logic               walk_ready,
  input logic [VPN_W-1:0]   walk_vpn,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               busy,
  input logic               miss,
  input logic               fill_take
);

  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_fault));

  a_r2_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r2_walk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> walk_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_vpn)));

  a_r3_done: assert property (@(posedge clk) disable iff (!rst_n)
    fill_take |=> !busy);

  a_r4_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !fill_take) |=> (hit_vec == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!req_ready && !miss));

  a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_take) |=> !busy);

endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES (ENTRIES),
  .VPN_W   (VPN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .walk_valid (walk_valid),
  .walk_ready (walk_ready),
  .walk_vpn   (walk_vpn),
  .hit_vec    (hit_vec),
  .busy       (busy),
  .miss       (miss),
  .fill_take  (fill_take)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_pa;
  logic        rsp_was_dirty;
  logic        walk_valid;
  logic        walk_ready = 1'b0;
  logic [19:0] walk_vpn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_ppn = '0;
  logic        fill_read = 1'b0;
  logic        fill_write = 1'b0;
  logic        fill_user = 1'b0;
  logic        fill_dirty = 1'b0;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk (clk), .rst_n (rst_n), .flush (flush),
    .req_valid (req_valid), .req_ready (req_ready), .req_va (req_va),
    .req_write (req_write), .req_user (req_user),
    .rsp_valid (rsp_valid), .rsp_fault (rsp_fault), .rsp_pa (rsp_pa),
    .rsp_was_dirty (rsp_was_dirty),
    .walk_valid (walk_valid), .walk_ready (walk_ready), .walk_vpn (walk_vpn),
    .fill_valid (fill_valid), .fill_ppn (fill_ppn), .fill_read (fill_read),
    .fill_write (fill_write), .fill_user (fill_user), .fill_dirty (fill_dirty)
  );

  // Bench page table: attributes computed from the page number
  function automatic logic [19:0] pt_ppn(input logic [19:0] v);
    return 20'(v * 20'd3 + 20'd7);
  endfunction

  function automatic bit exp_deny(input logic [19:0] v, input bit wr, input bit usr);
    return (usr && !v[2]) || (wr && !v[1]) || (!wr && !v[0]);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic [19:0] vpn, input logic [11:0] off,
                           input bit wr, input bit usr, input int stall,
                           input bit flush_fill,
                           output bit missed, output bit vld, output bit flt,
                           output bit drt, output logic [31:0] pa);
    missed = 1'b0; vld = 1'b0; flt = 1'b0; drt = 1'b0; pa = '0;
    @(negedge clk);
    req_valid = 1'b1; req_va = {vpn, off}; req_write = wr; req_user = usr;
    forever begin
      #1;
      if (req_ready) begin
        vld = rsp_valid; flt = rsp_fault; drt = rsp_was_dirty; pa = rsp_pa;
        break;
      end
      missed = 1'b1;
      @(negedge clk);
      for (int s = 0; s < stall; s++) begin
        check(walk_valid === 1'b1 && walk_vpn === vpn, "R2 walk hold",
              {43'd0, walk_valid, walk_vpn}, {43'd0, 1'b1, vpn});
        @(negedge clk);
      end
      check(walk_valid === 1'b1 && walk_vpn === vpn, "R2 walk request",
            {43'd0, walk_valid, walk_vpn}, {43'd0, 1'b1, vpn});
      walk_ready = 1'b1;
      @(negedge clk);
      walk_ready = 1'b0;
      fill_valid = 1'b1; fill_ppn = pt_ppn(vpn);
      fill_read = vpn[0]; fill_write = vpn[1]; fill_user = vpn[2]; fill_dirty = vpn[3];
      if (flush_fill) flush = 1'b1;
      @(negedge clk);
      fill_valid = 1'b0; flush = 1'b0;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    bit m, v, f, d;
    logic [31:0] pa;
    bit dmod [8];
    logic [19:0] base;
    logic [19:0] xv;
    base = 20'h12340;
    xv   = 20'h12349;
    foreach (dmod[i]) dmod[i] = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(walk_valid === 1'b0 && rsp_valid === 1'b0 && rsp_fault === 1'b0,
          "R9 reset outputs", {61'd0, walk_valid, rsp_valid, rsp_fault}, 64'd0);

    // Sweep: eight pages, all permission patterns, every mode/type pair
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 4; c++) begin
        logic [19:0] vp;
        logic [11:0] off;
        bit wr, usr, dn;
        vp  = base + 20'(k);
        off = 12'(k * 291 + c * 17);
        wr  = c[0];
        usr = c[1];
        dn  = exp_deny(vp, wr, usr);
        do_access(vp, off, wr, usr, (k == 0 && c == 0) ? 3 : 0, 1'b0, m, v, f, d, pa);
        check(m == (c == 0), "R2 R9 miss on first touch", {63'd0, m}, {63'd0, c == 0});
        check(f == dn, "R5 fault", {63'd0, f}, {63'd0, dn});
        check(v == !dn, "R1 valid", {63'd0, v}, {63'd0, !dn});
        if (!dn)
          check(pa === {pt_ppn(vp), off}, "R1 R3 address", {32'd0, pa}, {32'd0, pt_ppn(vp), off});
        check(d == dmod[k], "R6 dirty", {63'd0, d}, {63'd0, dmod[k]});
        if (!dn && wr) dmod[k] = 1'b1;
      end
    end

    // Replacement once full: pointer starts at slot 0
    do_access(xv, 12'h010, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b1, "R4 new page misses", {63'd0, m}, 64'd1);
    check(d == 1'b1 && v == 1'b1, "R6 dirty seeded by refill", {62'd0, d, v}, 64'd3);
    do_access(base + 20'd2, 12'h020, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b0, "R4 slot2 kept", {63'd0, m}, 64'd0);
    do_access(base, 12'h030, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b1, "R4 slot0 evicted", {63'd0, m}, 64'd1);
    do_access(base + 20'd1, 12'h040, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b1, "R4 slot1 evicted second", {63'd0, m}, 64'd1);
    do_access(base + 20'd3, 12'h050, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b0, "R4 slot3 kept", {63'd0, m}, 64'd0);
    do_access(xv, 12'h060, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b0, "R4 new page resident", {63'd0, m}, 64'd0);

    // Flush with a request present
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_va = {base + 20'd3, 12'h070};
    req_write = 1'b0; req_user = 1'b0;
    #1;
    check(req_ready === 1'b0, "R7 lookup held during flush", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    #1;
    check(walk_valid === 1'b0, "R7 no walk from flush cycle", {63'd0, walk_valid}, 64'd0);
    do_access(base + 20'd3, 12'h080, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b1, "R7 entry cleared", {63'd0, m}, 64'd1);

    // Flush in the refill cycle
    do_access(base + 20'd5, 12'h090, 1'b0, 1'b0, 0, 1'b1, m, v, f, d, pa);
    check(m == 1'b1 && v == 1'b1, "R8 refill completes", {62'd0, m, v}, 64'd3);
    check(pa === {pt_ppn(base + 20'd5), 12'h090}, "R8 address", {32'd0, pa},
          {32'd0, pt_ppn(base + 20'd5), 12'h090});
    do_access(base + 20'd5, 12'h0a0, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b0, "R8 refilled entry survives", {63'd0, m}, 64'd0);
    do_access(base + 20'd3, 12'h0b0, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b1, "R8 older entry cleared", {63'd0, m}, 64'd1);

    // Stray refill with no miss pending
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    fill_valid = 1'b1; fill_ppn = 20'h0beef;
    fill_read = 1'b1; fill_write = 1'b1; fill_user = 1'b1; fill_dirty = 1'b0;
    @(negedge clk); fill_valid = 1'b0;
    do_access(base + 20'd3, 12'h0c0, 1'b0, 1'b0, 0, 1'b0, m, v, f, d, pa);
    check(m == 1'b1, "R3 stray refill ignored", {63'd0, m}, 64'd1);
    check(v == 1'b1 && pa === {pt_ppn(base + 20'd3), 12'h0c0}, "R3 address after walk",
          {31'd0, v, pa}, {31'd0, 1'b1, pt_ppn(base + 20'd3), 12'h0c0});

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule